// File: doc/BRIEF.md
# RTC Register Unlock Gate

This block decides whether the register file of a real-time clock may be used. It has two independent locks. The first is a one-way activation latch. It leaves its power-on state only when one exact 32-bit word is written to the activation register. After that nothing short of a hardware reset clears it. The second is an access flag. Writing the right 16-bit key to the key register sets it, and writing any other key value clears it.

The block sits on a simple register bus: address, write enable, write data and combinational read data. It owns the two control registers and passes the rest of the address space to the clock's other registers. A write to any other address is forwarded on `protWrEn` only while the access flag is set. Read data from the other registers is passed through only while the flag is set, and reads as zero otherwise. The flag is also driven out as `accessEn`, so that other logic can qualify its own operation.

Top module: `rtc_gate_top`

## Requirements
- R1: During and right after hardware reset, `rtcActive` and `accessEn` are 0 and `protWrEn` is 0.
- R2: A write of 0xA5EB1357 to address 0x00 sets `rtcActive` on the next clock edge. A read of address 0x00 then returns 1 in bit 0. This works whether or not the access flag is set.
- R3: Once `rtcActive` is 1, it stays 1 until hardware reset, whatever is written to any address. Any other value written to address 0x00 leaves `rtcActive` unchanged.
- R4: A read of address 0x00 returns 0 in bits 31:1. The activation key can be written but never read back.
- R5: A write to address 0x04 whose bits 15:0 equal 0xA965 sets the access flag on the next edge. Bits 31:16 of that write are ignored.
- R6: A write to address 0x04 with any other value in bits 15:0 clears the access flag on the next edge.
- R7: A read of address 0x04 returns the access flag in bit 16 and zero in every other bit. The key field reads 0.
- R8: While the access flag is 0, a write to any address other than 0x00 and 0x04 does not assert `protWrEn`. A read of any such address returns 0.
- R9: While the access flag is 1, a write to any address other than 0x00 and 0x04 asserts `protWrEn` in the same cycle. A read of such an address returns `protRdData` unchanged.
- R10: `accessEn` always equals the access flag.
- R11: A write to address 0x00 or 0x04 never asserts `protWrEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hardware reset, asynchronous |
| busAddr | input | 8 | Byte address of the register access |
| busWrEn | input | 1 | Write strobe for the current cycle |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for `busAddr` |
| protRdData | input | 32 | Read data from the clock's other registers |
| protWrEn | output | 1 | Write strobe forwarded to the other registers |
| accessEn | output | 1 | Access flag, used to qualify other logic |
| rtcActive | output | 1 | Activation latch |

## Verification
The two state bits change on the clock edge that samples a write, so `rtcActive`, `accessEn` and the control-register read data are due one edge after the write. `protWrEn` and the pass-through read data are combinational and are due in the same cycle as the bus inputs. The bench drives the inputs on the falling edge and compares every output shortly after, against a model that updates its own state only at the rising edge. Each result is therefore judged in the cycle where it is due.

// File: rtl/rtc_gate_pkg.sv
package rtc_gate_pkg;
  // Strobes passed from the bus decoder to the state datapath.
  typedef struct packed {
    logic armActive;   // exact activation word written
    logic setAccess;   // exact access key written
    logic clrAccess;   // key register written with any other value
    logic fwdWrite;    // write aimed at a protected address
    logic selActive;   // read select: activation register
    logic selKey;      // read select: key register
  } gateStrobe_t;
endpackage

// File: rtl/rtc_gate_ctrl.sv
module rtc_gate_ctrl
  import rtc_gate_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned KEY_W      = 16,
  parameter int unsigned ACT_OFS    = 0,
  parameter int unsigned KEY_OFS    = 4,
  parameter logic [DATA_W-1:0] ACT_WORD = 32'hA5EB1357,
  parameter logic [KEY_W-1:0]  KEY_WORD = 16'hA965
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output gateStrobe_t       strobe
);
  localparam logic [ADDR_W-1:0] ActAddr = ADDR_W'(ACT_OFS);
  localparam logic [ADDR_W-1:0] KeyAddr = ADDR_W'(KEY_OFS);

  logic hitAct;
  logic hitKey;
  logic keyMatch;

  always_comb begin
    hitAct   = (busAddr == ActAddr);
    hitKey   = (busAddr == KeyAddr);
    keyMatch = (busWrData[KEY_W-1:0] == KEY_WORD);

    strobe.armActive = busWrEn && hitAct && (busWrData == ACT_WORD);
    strobe.setAccess = busWrEn && hitKey && keyMatch;
    strobe.clrAccess = busWrEn && hitKey && !keyMatch;
    strobe.fwdWrite  = busWrEn && !hitAct && !hitKey;
    strobe.selActive = hitAct;
    strobe.selKey    = hitKey;
  end
endmodule

// File: rtl/rtc_gate_state.sv
module rtc_gate_state
  import rtc_gate_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ENF_POS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  gateStrobe_t       strobe,
  input  logic [DATA_W-1:0] protRdData,
  output logic [DATA_W-1:0] busRdData,
  output logic              protWrEn,
  output logic              accessEn,
  output logic              rtcActive
);
  logic activeQ;
  logic accessQ;

  // One-way latch: no strobe clears it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 activeQ <= 1'b0;
    else if (strobe.armActive) activeQ <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 accessQ <= 1'b0;
    else if (strobe.setAccess) accessQ <= 1'b1;
    else if (strobe.clrAccess) accessQ <= 1'b0;
  end

  always_comb begin
    busRdData = '0;
    if (strobe.selActive)   busRdData[0]       = activeQ;
    else if (strobe.selKey) busRdData[ENF_POS] = accessQ;
    else if (accessQ)       busRdData          = protRdData;
  end

  assign protWrEn  = strobe.fwdWrite && accessQ;
  assign accessEn  = accessQ;
  assign rtcActive = activeQ;
endmodule

// File: rtl/rtc_gate_top.sv
module rtc_gate_top
  import rtc_gate_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned KEY_W   = 16,
  parameter int unsigned ACT_OFS = 0,
  parameter int unsigned KEY_OFS = 4,
  parameter logic [DATA_W-1:0] ACT_WORD = 32'hA5EB1357,
  parameter logic [KEY_W-1:0]  KEY_WORD = 16'hA965
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [DATA_W-1:0] protRdData,
  output logic              protWrEn,
  output logic              accessEn,
  output logic              rtcActive
);
  // Flag sits just above the key field.
  localparam int unsigned EnfPos = KEY_W;

  gateStrobe_t strobe;

  rtc_gate_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_W(KEY_W),
    .ACT_OFS(ACT_OFS), .KEY_OFS(KEY_OFS),
    .ACT_WORD(ACT_WORD), .KEY_WORD(KEY_WORD)
  ) u_ctrl (
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .strobe(strobe)
  );

  rtc_gate_state #(.DATA_W(DATA_W), .ENF_POS(EnfPos)) u_state (
    .clk(clk), .rstN(rstN), .strobe(strobe), .protRdData(protRdData),
    .busRdData(busRdData), .protWrEn(protWrEn),
    .accessEn(accessEn), .rtcActive(rtcActive)
  );
endmodule

// File: rtl/rtc_gate_chk.sv
module rtc_gate_chk #(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned KEY_W   = 16,
  parameter int unsigned ACT_OFS = 0,
  parameter int unsigned KEY_OFS = 4,
  parameter logic [DATA_W-1:0] ACT_WORD = 32'hA5EB1357,
  parameter logic [KEY_W-1:0]  KEY_WORD = 16'hA965
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [DATA_W-1:0] busWrData,
  input logic [DATA_W-1:0] busRdData,
  input logic [DATA_W-1:0] protRdData,
  input logic              protWrEn,
  input logic              accessEn,
  input logic              rtcActive
);
  localparam logic [ADDR_W-1:0] ActAddr = ADDR_W'(ACT_OFS);
  localparam logic [ADDR_W-1:0] KeyAddr = ADDR_W'(KEY_OFS);

  logic isCtrl;
  assign isCtrl = (busAddr == ActAddr) || (busAddr == KeyAddr);

  // R2
  arm_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ActAddr && busWrData == ACT_WORD) |=> rtcActive);

  // R3
  active_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    rtcActive |=> rtcActive);

  // R3
  active_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rtcActive) |-> $past(busWrEn && busAddr == ActAddr && busWrData == ACT_WORD));

  // R4
  act_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ActAddr) |-> (busRdData == {{(DATA_W-1){1'b0}}, rtcActive}));

  // R5
  key_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == KeyAddr && busWrData[KEY_W-1:0] == KEY_WORD) |=> accessEn);

  // R6
  key_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == KeyAddr && busWrData[KEY_W-1:0] != KEY_WORD) |=> !accessEn);

  // R8
  locked_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !accessEn |-> !protWrEn);

  // R8
  locked_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!accessEn && !isCtrl) |-> (busRdData == '0));

  // R9
  open_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accessEn && !isCtrl) |-> (busRdData == protRdData));

  // R11
  ctrl_no_fwd_chk: assert property (@(posedge clk) disable iff (!rstN)
    isCtrl |-> !protWrEn);
endmodule

bind rtc_gate_top rtc_gate_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_W(KEY_W),
  .ACT_OFS(ACT_OFS), .KEY_OFS(KEY_OFS),
  .ACT_WORD(ACT_WORD), .KEY_WORD(KEY_WORD)
) u_chk (.*);

// File: tb/test_rtc_gate_top.sv
module test_rtc_gate_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [31:0] protRdData = '0;
  logic        protWrEn;
  logic        accessEn;
  logic        rtcActive;

  int testsRun = 0;
  int testsFailed = 0;
  bit mActive = 1'b0;
  bit mEnf = 1'b0;

  always #5 clk = ~clk;

  rtc_gate_top i_rtc_gate_top (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .protRdData(protRdData),
    .protWrEn(protWrEn), .accessEn(accessEn), .rtcActive(rtcActive)
  );

  task automatic check32(string req, string what, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(logic [7:0] a, logic [31:0] prd);
    if (a == 8'h00) return {31'b0, mActive};
    if (a == 8'h04) return {15'b0, mEnf, 16'b0};
    return mEnf ? prd : 32'h0;
  endfunction

  // One bus cycle: drive, compare against model, then advance model at the edge.
  task automatic step(string req, logic [7:0] a, logic we, logic [31:0] d, logic [31:0] prd);
    @(negedge clk);
    busAddr = a; busWrEn = we; busWrData = d; protRdData = prd;
    #1;
    check32(req, "busRdData", busRdData, expRead(a, prd));
    check32(req, "protWrEn", {31'b0, protWrEn},
            {31'b0, we && mEnf && a != 8'h00 && a != 8'h04});
    check32("R10", "accessEn", {31'b0, accessEn}, {31'b0, mEnf});
    check32(req, "rtcActive", {31'b0, rtcActive}, {31'b0, mActive});
    @(posedge clk);
    if (we && a == 8'h00 && d == 32'hA5EB1357) mActive = 1'b1;
    if (we && a == 8'h04) mEnf = (d[15:0] == 16'hA965);
  endtask

  initial begin
    #2000000;
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [31:0] lfsr = 32'h1234_5678;
    // R1 reset state
    repeat (3) @(negedge clk);
    check32("R1", "rtcActive in reset", {31'b0, rtcActive}, 32'h0);
    check32("R1", "accessEn in reset", {31'b0, accessEn}, 32'h0);
    check32("R1", "protWrEn in reset", {31'b0, protWrEn}, 32'h0);
    rstN = 1'b1;
    step("R1", 8'h00, 1'b0, 32'h0, 32'h0);
    step("R4", 8'h00, 1'b0, 32'h0, 32'hFFFF_FFFF);
    step("R7", 8'h04, 1'b0, 32'h0, 32'hFFFF_FFFF);
    // R8 locked: protected write and read blocked
    step("R8", 8'h10, 1'b1, 32'hDEAD_BEEF, 32'hCAFE_F00D);
    step("R8", 8'h3C, 1'b0, 32'h0, 32'h0000_0001);
    // R3 near-miss activation word
    step("R3", 8'h00, 1'b1, 32'hA5EB_1356, 32'h0);
    step("R3", 8'h00, 1'b0, 32'h0, 32'h0);
    // R6 wrong key while clear
    step("R6", 8'h04, 1'b1, 32'h0000_A964, 32'h0);
    step("R7", 8'h04, 1'b0, 32'h0, 32'h0);
    // R5 right key with junk in upper half
    step("R5", 8'h04, 1'b1, 32'hFFFF_A965, 32'h0);
    step("R7", 8'h04, 1'b0, 32'h0, 32'h0);
    // R9 open: forward and pass through
    step("R9", 8'h10, 1'b1, 32'h1234_5678, 32'hA5A5_5A5A);
    step("R9", 8'h8C, 1'b0, 32'h0, 32'h0BAD_CAFE);
    // R11 control writes never forwarded
    step("R11", 8'h04, 1'b1, 32'h0000_A965, 32'h0);
    step("R11", 8'h00, 1'b1, 32'h0000_0000, 32'h0);
    // R6 wrong key clears
    step("R6", 8'h04, 1'b1, 32'h0000_0000, 32'h0);
    step("R8", 8'h20, 1'b1, 32'h5555_5555, 32'h7777_7777);
    // R2 activation while locked
    step("R2", 8'h00, 1'b1, 32'hA5EB_1357, 32'h0);
    step("R2", 8'h00, 1'b0, 32'h0, 32'h0);
    step("R4", 8'h00, 1'b1, 32'hFFFF_FFFF, 32'h0);
    step("R4", 8'h00, 1'b0, 32'h0, 32'h0);
    // R3 sticky under mixed traffic
    for (int i = 0; i < 200; i++) begin
      logic [7:0] a;
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;
      case (lfsr[3:1])
        3'd0, 3'd1: a = 8'h00;
        3'd2, 3'd3: a = 8'h04;
        3'd4:       a = 8'h0C;
        3'd5:       a = 8'h28;
        default:    a = 8'h44;
      endcase
      step("R3", a, lfsr[4],
           lfsr[5] ? {lfsr[31:16], 16'hA965} : lfsr, {lfsr[15:0], lfsr[31:16]});
    end
    // R1 reset clears both states
    @(negedge clk);
    rstN = 1'b0; busWrEn = 1'b0;
    mActive = 1'b0; mEnf = 1'b0;
    #1;
    check32("R1", "rtcActive after reset", {31'b0, rtcActive}, 32'h0);
    check32("R1", "accessEn after reset", {31'b0, accessEn}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    step("R1", 8'h10, 1'b1, 32'h1, 32'h1);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule